// File: doc/BRIEF.md
# Two-Stage I2C Serial Clock Baud Generator

This block derives serial-clock timing for an I2C master from a fast system clock. A small configuration word holds two divisor fields. One is a power-of-two exponent that drives a free-running prescaler. The other is a linear factor that counts prescaler pulses. The result is a phase tick. Ten phase ticks make one serial-clock period, so the bit engine that follows can place its data and clock edges on a grid ten times finer than SCL.

A mode input selects between two exponent conventions. In the default convention the prescaler divides by two raised to one more than the exponent field. In the alternate convention it divides by two raised to the exponent field itself. The block also drives a nominal SCL level derived from the phase count. While the bus enable is low, every counter is held at zero. Any write to the configuration word restarts the whole chain from a clean phase.

Top module: `scl_baud_gen`

## Requirements
- R1: After reset, `phase_tick` is 0, `phase_idx` is 0, `scl_out` is 1, and both divisor fields are 0. Enabling the bus without a prior write therefore gives a tick period of 2 clocks in the default mode.
- R2: A write with `cfg_wr` high loads N from `cfg_data[2:0]` and M from `cfg_data[6:3]`.
- R3: With `exp_mode` = 0, `phase_tick` pulses once every D = (M+1)·2^(N+1) clocks.
- R4: With `exp_mode` = 1, `phase_tick` pulses once every D = (M+1)·2^N clocks.
- R5: When D is 2 or more, each `phase_tick` pulse lasts exactly one clock.
- R6: Let a configuration write be sampled at clock edge E. With the bus enabled, ticks then appear after edges E+D, E+2D, and so on, whatever phase the chain was in before the write.
- R7: `phase_idx` advances by one on each tick and wraps from 9 to 0.
- R8: `scl_out` is 1 while `phase_idx` is 0 to 4 and 0 while it is 5 to 9. One SCL period therefore lasts 10·D clocks.
- R9: While `bus_en` is low, no tick occurs, `phase_idx` stays 0 and `scl_out` stays 1. If L is the last edge that samples `bus_en` low, the first tick follows edge L+D.
- R10: The range extremes work. M=15, N=7 in the default mode gives D=4096. M=0, N=0 in the alternate mode gives D=1, a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus enable; low holds all counters cleared |
| cfg_wr | input | 1 | Write strobe for the divisor configuration |
| cfg_data | input | 7 | Configuration word: N in [2:0], M in [6:3] |
| exp_mode | input | 1 | 0: prescale by 2^(N+1); 1: prescale by 2^N |
| phase_tick | output | 1 | One-clock pulse at ten times the SCL rate |
| phase_idx | output | 4 | Current phase within the SCL period, 0 to 9 |
| scl_out | output | 1 | Nominal SCL level: high in phases 0-4, low in 5-9 |

## Verification
On every cycle, the assertions check four things. A clear empties each counter on the next cycle. The linear count never passes M. The phase index stays below ten, wraps correctly and agrees with the SCL level. A disabled bus holds the outputs at their idle values, and a tick is never followed by a second one when D is two or more. The exact tick period for each field and mode combination, the cycle of the first tick after a write or an enable, and the restart of a period cut short by a new write are shown only by the scoreboard scenarios. Those scenarios predict every tick's cycle, phase and SCL level from the formula.

// File: rtl/scl_baud_pkg.sv
package scl_baud_pkg;

  // Exponent convention for the power-of-two stage
  typedef enum logic {
    EXP_PLUS_ONE = 1'b0,   // divide by 2^(N+1)
    EXP_PLAIN    = 1'b1    // divide by 2^N
  } exp_mode_e;

  // Field placement inside the configuration word
  localparam int N_FIELD_LSB = 0;

endpackage

// File: rtl/pow2_prescaler.sv
module pow2_prescaler
  import scl_baud_pkg::*;
#(
  parameter int N_W = 3,
  localparam int CNT_W = 1 << N_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           exp_sel,
  input  logic [N_W-1:0] n_val,
  output logic           hit
);

  logic [N_W:0]       expo;
  logic [CNT_W-1:0]   term;
  logic [CNT_W-1:0]   cnt;

  // effective exponent: N or N+1 depending on the convention
  always_comb begin
    expo = {1'b0, n_val} + ((exp_mode_e'(exp_sel) == EXP_PLAIN) ? '0 : (N_W+1)'(1));
  end

  // terminal count 2^expo - 1, built as a thermometer mask
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      term[i] = (expo > (N_W+1)'(i));
    end
  end

  assign hit = (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_pre_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/linear_stage.sv
module linear_stage #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic [M_W-1:0] m_val,
  output logic           hit
);

  logic [M_W-1:0] cnt;

  assign hit = step && (cnt == m_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (hit) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_lin_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= m_val);

  assert_lin_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int PHASES      = 10,
  parameter int HIGH_PHASES = 5,
  localparam int IDX_W = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic             tick,
  output logic [IDX_W-1:0] idx,
  output logic             scl
);

  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(PHASES - 1);
  localparam logic [IDX_W-1:0] HIGH_V = IDX_W'(HIGH_PHASES);

  logic [IDX_W-1:0] nxt;

  assign nxt = (idx == LAST_V) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tick <= 1'b0;
      idx  <= '0;
      scl  <= 1'b1;
    end else begin
      tick <= adv;
      if (adv) begin
        idx <= nxt;
        scl <= (nxt < HIGH_V);
      end
    end
  end

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_V);

  assert_idx_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && idx == LAST_V) |=> (idx == '0));

  assert_scl_level_R8: assert property (@(posedge clk) disable iff (rst)
    scl == (idx < HIGH_V));

endmodule

// File: rtl/scl_baud_gen.sv
module scl_baud_gen
  import scl_baud_pkg::*;
#(
  parameter int M_W         = 4,
  parameter int N_W         = 3,
  parameter int PHASES      = 10,
  parameter int HIGH_PHASES = 5,
  localparam int IDX_W = $clog2(PHASES),
  localparam int CFG_W = M_W + N_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             exp_mode,
  output logic             phase_tick,
  output logic [IDX_W-1:0] phase_idx,
  output logic             scl_out
);

  localparam int M_LSB = N_FIELD_LSB + N_W;

  logic [M_W-1:0] cfg_m;
  logic [N_W-1:0] cfg_n;
  logic           clr;
  logic           pre_hit;
  logic           lin_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_m <= '0;
      cfg_n <= '0;
    end else if (cfg_wr) begin
      cfg_n <= cfg_data[N_FIELD_LSB +: N_W];
      cfg_m <= cfg_data[M_LSB +: M_W];
    end
  end

  // a write or a disabled bus restarts the whole chain
  assign clr = !bus_en || cfg_wr;

  pow2_prescaler #(.N_W(N_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .exp_sel (exp_mode),
    .n_val   (cfg_n),
    .hit     (pre_hit)
  );

  linear_stage #(.M_W(M_W)) u_lin (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .step  (pre_hit),
    .m_val (cfg_m),
    .hit   (lin_hit)
  );

  phase_ring #(.PHASES(PHASES), .HIGH_PHASES(HIGH_PHASES)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .adv  (lin_hit),
    .tick (phase_tick),
    .idx  (phase_idx),
    .scl  (scl_out)
  );

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> (!phase_tick && scl_out && phase_idx == '0));

  assert_tick_width_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_tick && (cfg_m != '0 || cfg_n != '0 || exp_mode == EXP_PLUS_ONE))
      |=> (!phase_tick || (cfg_m == '0 && cfg_n == '0 && exp_mode == EXP_PLAIN)));

endmodule

// File: tb/scl_baud_gen_test.sv
module scl_baud_gen_test;

  localparam int PHASES = 10;
  localparam int HIGH   = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_data = '0;
  logic       exp_mode = 1'b0;
  logic       phase_tick;
  logic [3:0] phase_idx;
  logic       scl_out;

  always #4 clk = ~clk;

  scl_baud_gen uut (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .cfg_wr     (cfg_wr),
    .cfg_data   (cfg_data),
    .exp_mode   (exp_mode),
    .phase_tick (phase_tick),
    .phase_idx  (phase_idx),
    .scl_out    (scl_out)
  );

  typedef struct {
    int cyc;
    int idx;
    bit scl;
  } exp_t;

  exp_t  sb[$];
  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    win_lo = 0;
  int    win_hi = -1;
  int    cur_d = 2;
  string cur_tag = "R1";
  bit    chk_low = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: counts edges, samples 2 ns after each edge
  always @(posedge clk) begin
    exp_t e;
    cyc++;
    #2;
    if (chk_low) begin
      check(phase_tick == 1'b0, "R5", "tick still high one clock later", int'(phase_tick), 0);
      chk_low = 1'b0;
    end
    if (cyc > win_lo && cyc <= win_hi && phase_tick) begin
      if (sb.size() == 0) begin
        check(1'b0, cur_tag, "unexpected tick at cycle", cyc, -1);
      end else begin
        e = sb.pop_front();
        check(e.cyc == cyc, cur_tag, "tick cycle", cyc, e.cyc);
        check(int'(phase_idx) == e.idx, "R7", "phase index", int'(phase_idx), e.idx);
        check(scl_out == e.scl, "R8", "scl level", int'(scl_out), int'(e.scl));
        if (cur_d >= 2) chk_low = 1'b1;
      end
    end
  end

  // driver side: predict the tick train of one window
  task automatic arm(int e0, int d, int ticks, int hold, string tag);
    cur_d   = d;
    cur_tag = tag;
    win_lo  = e0;
    win_hi  = (ticks > 0) ? e0 + ticks * d : e0 + hold;
    for (int j = 1; j <= ticks; j++) begin
      exp_t e;
      e.cyc = e0 + j * d;
      e.idx = j % PHASES;
      e.scl = ((j % PHASES) < HIGH);
      sb.push_back(e);
    end
  endtask

  task automatic close_win(string tag);
    while (cyc < win_hi) @(negedge clk);
    check(sb.size() == 0, tag, "expected ticks not seen", sb.size(), 0);
    sb.delete();
  endtask

  task automatic run_cfg(int m, int n, bit mode, int ticks, int hold, string tag);
    int d;
    @(negedge clk);
    cfg_data = {m[3:0], n[2:0]};
    exp_mode = mode;
    cfg_wr   = 1'b1;
    d = (m + 1) * (1 << (n + (mode ? 0 : 1)));
    arm(cyc + 1, d, ticks, hold, tag);
    @(negedge clk);
    cfg_wr   = 1'b0;
    cfg_data = '0;
    close_win(tag);
  endtask

  task automatic run_enable(int d, int ticks, string tag);
    @(negedge clk);
    bus_en = 1'b1;
    arm(cyc, d, ticks, 0, tag);
    close_win(tag);
  endtask

  task automatic hold_check(int cycles);
    @(negedge clk);
    bus_en = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(phase_tick == 1'b0, "R9", "tick while disabled", int'(phase_tick), 0);
      check(phase_idx == 4'd0, "R9", "phase while disabled", int'(phase_idx), 0);
      check(scl_out == 1'b1, "R9", "scl while disabled", int'(scl_out), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(phase_tick == 1'b0, "R1", "reset tick", int'(phase_tick), 0);
    check(phase_idx == 4'd0, "R1", "reset phase", int'(phase_idx), 0);
    check(scl_out == 1'b1, "R1", "reset scl", int'(scl_out), 1);

    // R1 / R9: defaults M=0 N=0, default mode -> D=2
    run_enable(2, 12, "R1");
    // R3: default mode, M=3 N=1 -> D=16
    run_cfg(3, 1, 1'b0, 12, 0, "R3");
    // R4: alternate mode, same fields -> D=8
    run_cfg(3, 1, 1'b1, 12, 0, "R4");
    // R2: field placement, M=2 N=4 alternate -> D=48
    run_cfg(2, 4, 1'b1, 12, 0, "R2");
    // R10: tick on every clock
    run_cfg(0, 0, 1'b1, 12, 0, "R10");
    // R6: write cut short by a second write
    run_cfg(1, 1, 1'b0, 0, 5, "R6");
    run_cfg(5, 0, 1'b0, 12, 0, "R6");
    // R9: hold and re-enable with M=5 N=0 default -> D=12
    hold_check(20);
    run_enable(12, 12, "R9");
    // R10: largest divisor -> D=4096
    run_cfg(15, 7, 1'b0, 10, 0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule